// File: doc/BRIEF.md
# Per-Channel Frame Error Tracker

This block watches frame-start and frame-end events and payload CRC-error pulses for the twelve extended virtual channels, numbered 4 to 15. Each channel keeps its own small state: whether a frame is open, and whether a CRC error has arrived since that frame opened. When a frame-end event arrives, the block looks at that channel's state and may raise one of two sticky status bits for the channel.

The first bit is a synchronisation error. It is raised by a frame end that has no open frame on the same channel. The second bit is a frame-level error. It is raised by a frame end that closes an open frame during which a CRC error was seen. Events arrive as single-cycle strobes, each with a 4-bit channel number. Software reads a 32-bit status word, and it clears bits by writing ones to them.

Top module: `frame_err_tracker`

## Requirements
- R1: While reset is asserted and after it is released, with no events, `status` reads 0x00000000.
- R2: A frame end on channel c (4..15) while channel c has no open frame sets bit 2*(c-4)+1 of `status` (the sync error bit) on the clock edge that takes the strobe, and it leaves bit 2*(c-4) unchanged.
- R3: The sequence frame start, CRC error, frame end on the same channel c sets bit 2*(c-4) (the frame-level error bit). A frame start followed by a frame end with no CRC error in between sets neither bit.
- R4: A CRC error on a channel with no open frame is ignored. A second frame start on a channel that already has an open frame restarts the frame and discards any CRC error seen before it. A CRC error in the same cycle as that restarting frame start is also discarded.
- R5: Status bits are sticky. A write with `wrEn` high clears exactly the bits where `wrData` holds 1. Writing 0 to a bit leaves it unchanged.
- R6: If a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R7: Events on channels 0..3 have no effect. Bits 31:24 of `status` always read 0, and writing to them has no effect.
- R8: A CRC error in the same cycle as the frame end on its channel counts toward the frame being closed. After a frame end, the channel has no open frame, so a following frame end raises the sync error bit.
- R9: Each channel keeps independent state. Events on one channel never change another channel's state or bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fsValid | input | 1 | Frame-start strobe |
| fsChan | input | 4 | Channel of the frame start |
| feValid | input | 1 | Frame-end strobe |
| feChan | input | 4 | Channel of the frame end |
| crcErrValid | input | 1 | Payload CRC error strobe |
| crcErrChan | input | 4 | Channel of the CRC error |
| wrEn | input | 1 | Status write strobe |
| wrData | input | 32 | Write-one-to-clear mask |
| status | output | 32 | Sticky error bits, two per channel |

## Verification
A wrong open-frame flag does not show at the ports until that channel's next frame end. At that edge the wrong bit of the pair appears: the sync bit where the level bit was due, or the reverse. A stale CRC-seen flag shows only when a paired frame end closes the frame, as a spurious or missing level bit. For this reason the bench closes frames after every restart, after CRC pulses that fall outside a frame, and after simultaneous events. It then compares the whole status word one cycle after each strobe.

// File: rtl/fet_pkg.sv
package fet_pkg;
  localparam int CHAN_W  = 4;
  localparam int CH_BASE = 4;
  localparam int NUM_CH  = 12;
  localparam int REG_W   = 32;
  localparam int USED_W  = 2 * NUM_CH;

  typedef struct packed {
    logic [NUM_CH-1:0] syncSet;
    logic [NUM_CH-1:0] levelSet;
  } errStrobes_t;
endpackage

// File: rtl/fet_ctrl.sv
module fet_ctrl
  import fet_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsValid,
  input  logic [CHAN_W-1:0] fsChan,
  input  logic              feValid,
  input  logic [CHAN_W-1:0] feChan,
  input  logic              crcErrValid,
  input  logic [CHAN_W-1:0] crcErrChan,
  output errStrobes_t       strobes
);
  logic [NUM_CH-1:0] inFrame;
  logic [NUM_CH-1:0] crcSeen;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    localparam logic [CHAN_W-1:0] ChId = CHAN_W'(CH_BASE + i);
    logic fsHit, feHit, crcHit;

    assign fsHit  = fsValid && (fsChan == ChId);
    assign feHit  = feValid && (feChan == ChId);
    assign crcHit = crcErrValid && (crcErrChan == ChId) && inFrame[i];

    assign strobes.syncSet[i]  = feHit && !inFrame[i];
    assign strobes.levelSet[i] = feHit && inFrame[i] && (crcSeen[i] || crcHit);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inFrame[i] <= 1'b0;
        crcSeen[i] <= 1'b0;
      end else begin
        if (fsHit)      inFrame[i] <= 1'b1;
        else if (feHit) inFrame[i] <= 1'b0;
        if (fsHit)       crcSeen[i] <= 1'b0;
        else if (crcHit) crcSeen[i] <= 1'b1;
      end
    end
  end

  // R2
  sync_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.syncSet | strobes.levelSet));

  // R3
  level_needs_fe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.levelSet != '0) |-> feValid);

  // R8
  fe_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.levelSet != '0) && !fsValid) |=> ((inFrame & $past(strobes.levelSet)) == '0));
endmodule

// File: rtl/fet_dp.sv
module fet_dp
  import fet_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  errStrobes_t      strobes,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] status
);
  logic [USED_W-1:0] setVec;
  logic [USED_W-1:0] clrVec;
  logic [USED_W-1:0] bits;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_map
    assign setVec[2*i+1] = strobes.syncSet[i];
    assign setVec[2*i]   = strobes.levelSet[i];
  end

  assign clrVec = wrEn ? wrData[USED_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bits <= '0;
    else       bits <= setVec | (bits & ~clrVec);
  end

  assign status = {{(REG_W-USED_W){1'b0}}, bits};

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && (setVec == '0)) |=> $stable(status));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (setVec == '0)) |=> ((status[USED_W-1:0] & $past(wrData[USED_W-1:0])) == '0));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((status[USED_W-1:0] & $past(setVec)) == $past(setVec)));

  // R7
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[REG_W-1:USED_W] == '0);
endmodule

// File: rtl/frame_err_tracker.sv
module frame_err_tracker
  import fet_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              fsValid,
  input  logic [CHAN_W-1:0] fsChan,
  input  logic              feValid,
  input  logic [CHAN_W-1:0] feChan,
  input  logic              crcErrValid,
  input  logic [CHAN_W-1:0] crcErrChan,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  status
);
  errStrobes_t strobes;

  fet_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .fsValid(fsValid), .fsChan(fsChan),
    .feValid(feValid), .feChan(feChan),
    .crcErrValid(crcErrValid), .crcErrChan(crcErrChan),
    .strobes(strobes)
  );

  fet_dp u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes),
    .wrEn(wrEn), .wrData(wrData),
    .status(status)
  );
endmodule

// File: tb/tb_frame_err_tracker.sv
module tb_frame_err_tracker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fsValid = 0, feValid = 0, crcErrValid = 0, wrEn = 0;
  logic [3:0] fsChan = 0, feChan = 0, crcErrChan = 0;
  logic [31:0] wrData = 0;
  logic [31:0] status;

  int checks = 0;
  int fails = 0;
  logic mIn [16];
  logic mCrc [16];
  logic [31:0] expStatus;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_err_tracker dut (
    .clk(clk), .rstN(rstN),
    .fsValid(fsValid), .fsChan(fsChan),
    .feValid(feValid), .feChan(feChan),
    .crcErrValid(crcErrValid), .crcErrChan(crcErrChan),
    .wrEn(wrEn), .wrData(wrData),
    .status(status)
  );

  task automatic check(input string tag, input logic [31:0] expv);
    checks++;
    if (status !== expv) begin
      fails++;
      $display("FAIL %s: status=%08h expected=%08h", tag, status, expv);
    end
  endtask

  // Reference: evaluate one edge from the requirements
  task automatic modelStep();
    logic [31:0] setBits;
    setBits = '0;
    for (int c = 4; c < 16; c++) begin
      logic fsH, feH, crH;
      fsH = fsValid && fsChan == c;
      feH = feValid && feChan == c;
      crH = crcErrValid && crcErrChan == c && mIn[c];
      if (feH) begin
        if (!mIn[c]) setBits[2*(c-4)+1] = 1'b1;
        else if (mCrc[c] || crH) setBits[2*(c-4)] = 1'b1;
      end
      if (fsH) begin mIn[c] = 1'b1; mCrc[c] = 1'b0; end
      else begin
        if (feH) mIn[c] = 1'b0;
        if (crH) mCrc[c] = 1'b1;
      end
    end
    expStatus = setBits | (expStatus & ~(wrEn ? wrData : 32'h0));
    expStatus[31:24] = 8'h0;
  endtask

  task automatic cyc(input string tag,
                     input logic fv, input logic [3:0] fc,
                     input logic ev, input logic [3:0] ec,
                     input logic cv, input logic [3:0] cc,
                     input logic wv, input logic [31:0] wd);
    fsValid = fv; fsChan = fc; feValid = ev; feChan = ec;
    crcErrValid = cv; crcErrChan = cc; wrEn = wv; wrData = wd;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    fsValid = 0; feValid = 0; crcErrValid = 0; wrEn = 0;
    check(tag, expStatus);
  endtask

  task automatic fs(input string t, input logic [3:0] c);  cyc(t, 1, c, 0, 0, 0, 0, 0, 0); endtask
  task automatic fe(input string t, input logic [3:0] c);  cyc(t, 0, 0, 1, c, 0, 0, 0, 0); endtask
  task automatic crc(input string t, input logic [3:0] c); cyc(t, 0, 0, 0, 0, 1, c, 0, 0); endtask
  task automatic wr(input string t, input logic [31:0] d); cyc(t, 0, 0, 0, 0, 0, 0, 1, d); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: status=%08h expected=done", status);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int c = 0; c < 16; c++) begin mIn[c] = 0; mCrc[c] = 0; end
    expStatus = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", 32'h0);

    // R2: unpaired FE on ch7 -> bit 7
    fe("R2 unpaired fe", 7);
    check("R2 literal", 32'h0000_0080);
    // R5: write 0 to bit7 region, write 1 to bit6 (clear) -> bit7 remains
    wr("R5 no clear", 32'h0000_0040);
    check("R5 literal keep", 32'h0000_0080);
    wr("R5 clear", 32'h0000_0080);
    check("R5 literal cleared", 32'h0);
    // R3
    fs("R3 fs", 7); crc("R3 crc", 7); fe("R3 fe", 7);
    check("R3 literal level", 32'h0000_0040);
    wr("R3 clr", 32'hFFFF_FFFF);
    fs("R3 fs clean", 7); fe("R3 fe clean", 7);
    check("R3 literal clean", 32'h0);
    // R4: CRC outside frame, then restart discarding CRC
    crc("R4 crc idle", 9); fs("R4 fs", 9); fe("R4 fe", 9);
    check("R4 literal idle crc", 32'h0);
    fs("R4 fs1", 9); crc("R4 crc", 9); fs("R4 restart", 9); fe("R4 fe2", 9);
    check("R4 literal restart", 32'h0);
    fs("R4 fs3", 9);
    cyc("R4 crc with restart", 1, 9, 0, 0, 1, 9, 0, 0);
    fe("R4 fe3", 9);
    check("R4 literal crc at restart", 32'h0);
    // R8: CRC same cycle as FE, then second FE unpaired (ch5 -> bits 3:2)
    fs("R8 fs", 5);
    cyc("R8 fe+crc", 0, 0, 1, 5, 1, 5, 0, 0);
    check("R8 literal level", 32'h0000_0004);
    fe("R8 second fe", 5);
    check("R8 literal sync", 32'h0000_000C);
    // R6: set and clear same cycle on ch15 sync bit 23
    cyc("R6 set wins", 0, 0, 1, 15, 0, 0, 1, 32'hFFFF_FFFF);
    check("R6 literal", 32'h0080_0000);
    // R7: low channels ignored, reserved bits
    fe("R7 fe ch2", 2); fs("R7 fs ch0", 0); crc("R7 crc ch3", 3); fe("R7 fe ch0", 0);
    wr("R7 reserved write", 32'hFF00_0000);
    check("R7 literal", 32'h0080_0000);
    // R9: ch12 frame with CRC while ch13 unpaired FE
    fs("R9 fs12", 12); crc("R9 crc12", 12); fe("R9 fe13", 13);
    check("R9 literal ch13 only", 32'h0088_0000);
    fe("R9 fe12", 12);
    check("R9 literal ch12 level", 32'h0089_0000);
    wr("R9 clr", 32'hFFFF_FFFF);

    // Random mixed traffic
    for (int n = 0; n < 4000; n++) begin
      logic fv, ev, cv, wv;
      fv = ($urandom % 4) == 0;
      ev = ($urandom % 4) == 0;
      cv = ($urandom % 3) == 0;
      wv = ($urandom % 8) == 0;
      cyc("R9 random", fv, 4'($urandom), ev, 4'($urandom), cv, 4'($urandom),
          wv, $urandom);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule